// File: doc/BRIEF.md
# Serially programmed clock-select controller

This block is the digital control plane of a clock fanout device with two clock inputs and ten clock outputs. A three-wire serial port made of a load-enable line, a data line and a serial clock is used to write an 11-bit control word. While the load-enable line is low the block runs in a fallback mode. In that mode every output is on, and the data line itself chooses which clock input is fanned out. A rising edge on the load-enable line clears the programming state. The next eleven serial clock pulses shift in the word, and a twelfth pulse commits it to the control register. That register then selects the clock input and gates each output on or off.

The serial pins are brought into the block's own clock domain by a synchronizer chain of configurable depth, and their edges are found there. A pin event therefore takes effect `SYNC_STAGES + 1` cycles of `clk` after the pin changes. The clock inputs and outputs are modelled as logic signals. The selected clock reaches each output through an AND gate with that output's enable bit.

Top module: `clkfan_ctrl`

## Requirements
- R1: After `rst_n` is released with the load-enable and data pins low and the serial clock pin high (the idle levels of unconnected pins), every output follows `ref_clk_a`.
- R2: While the synchronized load-enable is low, every bit of `out_clk` equals `ref_clk_b` if the data pin is 1 and `ref_clk_a` if it is 0, whatever the control register holds.
- R3: While load-enable is high, each rising serial clock edge among the first eleven after the load-enable rise shifts the data pin into the word, the first bit shifted becoming word bit 0 and the eleventh becoming word bit 10.
- R4: In a committed word, bit 10 selects the input (0 = `ref_clk_a`, 1 = `ref_clk_b`) and bit 9−i enables `out_clk[i]`, so bit 9 drives output 0 and bit 0 drives output 9.
- R5: The twelfth rising serial clock edge after a load-enable rise copies the shifted word into the control register; before that edge the control register keeps its cleared value, so every output is low while load-enable is high.
- R6: A rising edge on load-enable clears the shift register, the pulse counter and the control register, and the count restarts from zero.
- R7: Serial clock edges after the commit pulse are ignored while load-enable stays high; the pulse counter saturates at twelve.
- R8: While load-enable is high, an output whose enable bit is 0 is driven low.
- R9: If load-enable falls before the twelfth pulse, nothing is committed, and the pulses already given do not count toward the next load sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Load-enable pin; high allows programming, its rising edge clears the state |
| prog_data | input | 1 | Serial data pin; also picks the input clock in fallback mode |
| prog_sck | input | 1 | Serial clock pin; data is taken on its rising edge |
| ref_clk_a | input | 1 | Clock input selected by a 0 |
| ref_clk_b | input | 1 | Clock input selected by a 1 |
| out_clk | output | NUM_OUT | Gated fanout of the selected clock |

## Verification
The fallback mode is tried with both data levels against both input-clock patterns, which separates a select taken from the data pin from one taken from the register. An asymmetric programmed word, with sparse enables and the select set, shows whether the shift direction and the reversed bit-to-output mapping are right. It is observed both with both clock inputs high and with only one high, so that gating and selection can be told apart. An aborted load followed by a fresh eleven pulses shows whether the counter really restarts, because a stale count would commit too early. Extra pulses after the commit and a repeated load-enable rise cover saturation and clearing.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

   // Idle pin levels: load-enable low, data low, serial clock high.
   typedef struct packed {
      logic en;
      logic dat;
      logic sck;
   } ser_pins_t;

   localparam ser_pins_t PINS_IDLE = '{en: 1'b0, dat: 1'b0, sck: 1'b1};

   // Counter width large enough for word length plus the commit and done states.
   function automatic int cnt_width(input int word_w);
      return $clog2(word_w + 2);
   endfunction

endpackage

// File: rtl/clkfan_sync.sv
module clkfan_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= RST_VAL;
            else        st <= d;
         end
         assign q = st;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/clkfan_edge.sv
module clkfan_edge #(
   parameter int           W       = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);

   logic [W-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= RST_VAL;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/clkfan_prog.sv
module clkfan_prog #(
   parameter int NUM_OUT = 10,
   parameter int WORD_W  = NUM_OUT + 1,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lvl,
   input  logic              en_rise,
   input  logic              sck_rise,
   input  logic              dat_lvl,
   output logic [WORD_W-1:0] shreg,
   output logic [WORD_W-1:0] ctrl,
   output logic [CNT_W-1:0]  cnt
);

   localparam logic [CNT_W-1:0] CNT_COMMIT = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

   logic take;
   assign take = en_lvl && sck_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         ctrl  <= '0;
         cnt   <= '0;
      end else if (en_rise) begin
         shreg <= '0;
         ctrl  <= '0;
         cnt   <= '0;
      end else if (take) begin
         if (cnt < CNT_COMMIT) begin
            shreg <= {dat_lvl, shreg[WORD_W-1:1]};
            cnt   <= cnt + CNT_ONE;
         end else if (cnt == CNT_COMMIT) begin
            ctrl <= shreg;
            cnt  <= cnt + CNT_ONE;
         end
      end
   end

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate #(
   parameter int NUM_OUT = 10,
   parameter int WORD_W  = NUM_OUT + 1
) (
   input  logic [WORD_W-1:0]  ctrl,
   input  logic               en_lvl,
   input  logic               dat_lvl,
   input  logic               ref_clk_a,
   input  logic               ref_clk_b,
   output logic [NUM_OUT-1:0] out_clk
);

   logic pick_b;
   logic clk_sel;

   assign pick_b  = en_lvl ? ctrl[WORD_W-1] : dat_lvl;
   assign clk_sel = pick_b ? ref_clk_b : ref_clk_a;

   generate
      for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
         logic on;
         assign on         = !en_lvl || ctrl[NUM_OUT-1-g];
         assign out_clk[g] = clk_sel & on;
      end
   endgenerate

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
   import clkfan_pkg::*;
#(
   parameter int NUM_OUT     = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               prog_en,
   input  logic               prog_data,
   input  logic               prog_sck,
   input  logic               ref_clk_a,
   input  logic               ref_clk_b,
   output logic [NUM_OUT-1:0] out_clk
);

   localparam int WORD_W = NUM_OUT + 1;
   localparam int CNT_W  = cnt_width(WORD_W);

   generate
      if (NUM_OUT < 1 || NUM_OUT > 60) begin : g_bad_out
         $error("clkfan_ctrl: NUM_OUT out of range");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("clkfan_ctrl: SYNC_STAGES out of range");
      end
   endgenerate

   ser_pins_t pins_raw, pins_s, pins_rise;

   assign pins_raw = '{en: prog_en, dat: prog_data, sck: prog_sck};

   clkfan_sync #(
      .W      (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PINS_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s)
   );

   clkfan_edge #(
      .W      (3),
      .RST_VAL(PINS_IDLE)
   ) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pins_s),
      .rise (pins_rise)
   );

   logic              en_lvl, dat_lvl, en_rise, sck_rise;
   logic [WORD_W-1:0] shreg, ctrl;
   logic [CNT_W-1:0]  cnt;

   assign en_lvl   = pins_s.en;
   assign dat_lvl  = pins_s.dat;
   assign en_rise  = pins_rise.en;
   assign sck_rise = pins_rise.sck;

   clkfan_prog #(
      .NUM_OUT(NUM_OUT),
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) u_prog (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_lvl  (en_lvl),
      .en_rise (en_rise),
      .sck_rise(sck_rise),
      .dat_lvl (dat_lvl),
      .shreg   (shreg),
      .ctrl    (ctrl),
      .cnt     (cnt)
   );

   clkfan_gate #(
      .NUM_OUT(NUM_OUT),
      .WORD_W (WORD_W)
   ) u_gate (
      .ctrl     (ctrl),
      .en_lvl   (en_lvl),
      .dat_lvl  (dat_lvl),
      .ref_clk_a(ref_clk_a),
      .ref_clk_b(ref_clk_b),
      .out_clk  (out_clk)
   );

endmodule

// File: rtl/clkfan_ctrl_chk.sv
module clkfan_ctrl_chk #(
   parameter int NUM_OUT = 10,
   parameter int WORD_W  = NUM_OUT + 1,
   parameter int CNT_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_lvl,
   input logic               en_rise,
   input logic               sck_rise,
   input logic               dat_lvl,
   input logic [WORD_W-1:0]  shreg,
   input logic [WORD_W-1:0]  ctrl,
   input logic [CNT_W-1:0]   cnt,
   input logic               ref_clk_a,
   input logic               ref_clk_b,
   input logic [NUM_OUT-1:0] out_clk
);

   localparam logic [CNT_W-1:0] CNT_COMMIT = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_DONE   = CNT_W'(WORD_W + 1);

   logic [NUM_OUT-1:0] ena_vec;
   always_comb begin
      for (int i = 0; i < NUM_OUT; i++) ena_vec[i] = ctrl[NUM_OUT-1-i];
   end

   logic commit_now;
   assign commit_now = !en_rise && en_lvl && sck_rise && (cnt == CNT_COMMIT);

   // R7: counter never passes the done state
   p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_DONE);

   // R6: load-enable rise clears everything
   p_en_rise_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> (cnt == '0 && ctrl == '0 && shreg == '0));

   // R5: commit pulse copies the word
   p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_now |=> (ctrl == $past(shreg)));

   // R9: without a commit pulse or clear, the register holds
   p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_rise && !commit_now) |=> $stable(ctrl));

   // R3: a data pulse lands in the top stage
   p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_rise && en_lvl && sck_rise && cnt < CNT_COMMIT)
         |=> (shreg[WORD_W-1] == $past(dat_lvl)));

   // R2: fallback mode fans the data-selected clock to every output
   p_fallback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lvl |-> (out_clk == {NUM_OUT{dat_lvl ? ref_clk_b : ref_clk_a}}));

   // R8: disabled outputs stay low
   p_gated_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en_lvl |-> ((out_clk & ~ena_vec) == '0));

endmodule

bind clkfan_ctrl clkfan_ctrl_chk #(
   .NUM_OUT(NUM_OUT),
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_lvl   (en_lvl),
   .en_rise  (en_rise),
   .sck_rise (sck_rise),
   .dat_lvl  (dat_lvl),
   .shreg    (shreg),
   .ctrl     (ctrl),
   .cnt      (cnt),
   .ref_clk_a(ref_clk_a),
   .ref_clk_b(ref_clk_b),
   .out_clk  (out_clk)
);

// File: tb/sim_clkfan_ctrl.sv
`timescale 1ns/1ps
module sim_clkfan_ctrl;

   localparam int N  = 10;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, si = 1'b0, ck = 1'b1;   // unconnected-pin levels
   logic ra = 1'b1, rb = 1'b0;
   logic [N-1:0] out;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   clkfan_ctrl #(.NUM_OUT(N), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .prog_en(en), .prog_data(si), .prog_sck(ck),
      .ref_clk_a(ra), .ref_clk_b(rb), .out_clk(out)
   );

   // ---------------- behavioural reference model ----------------
   bit [2:0] pq[$];          // delayed pin samples {en,si,ck}
   bit [2:0] m_cur, m_prev;
   bit       got[$];         // data bits received since last load-enable rise
   int       m_pulses;
   bit [10:0] m_word;

   function automatic logic [N-1:0] expect_out(bit e, bit s, bit [10:0] w, logic a, logic b);
      logic [N-1:0] r;
      logic c;
      if (!e) return {N{s ? b : a}};
      c = w[10] ? b : a;
      for (int i = 0; i < N; i++) r[i] = c & w[9-i];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pq.delete();
         for (int i = 0; i < SS - 1; i++) pq.push_back(3'b001);
         m_cur = 3'b001; m_prev = 3'b001;
         got.delete(); m_pulses = 0; m_word = '0;
      end else begin
         if (m_cur[2] && !m_prev[2]) begin
            got.delete(); m_pulses = 0; m_word = '0;
         end else if (m_cur[2] && m_cur[0] && !m_prev[0]) begin
            if (m_pulses < 11) begin
               got.push_back(m_cur[1]);
               m_pulses++;
            end else if (m_pulses == 11) begin
               for (int k = 0; k < 11; k++) m_word[k] = got[k];
               m_pulses++;
            end
         end
         m_prev = m_cur;
         pq.push_back({en, si, ck});
         m_cur = pq.pop_front();
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         logic [N-1:0] e;
         e = expect_out(m_cur[2], m_cur[1], m_word, ra, rb);
         nchk++;
         if (out !== e) begin
            nfail++;
            $display("FAIL %s model compare: out=%h expected=%h",
                     m_cur[2] ? "R8" : "R2", out, e);
         end
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(bit b);
      @(negedge clk); si = b;
      idle(3); ck = 1'b0;
      idle(3); ck = 1'b1;
      idle(4);
   endtask

   task automatic send_bits(bit [10:0] w, int nbits);
      for (int k = 0; k < nbits; k++) pulse(w[k]);
   endtask

   task automatic chk(string tag, logic [N-1:0] exp);
      @(posedge clk); #2;
      nchk++;
      if (out !== exp) begin
         nfail++;
         $display("FAIL %s: out=%h expected=%h", tag, out, exp);
      end
   endtask

   initial begin
      idle(5); rst_n = 1'b1; idle(4);
      chk("R1 reset idle", 10'h3FF);

      si = 1; idle(4);
      chk("R2 data=1 picks b", 10'h000);
      ra = 0; rb = 1; idle(1);
      chk("R2 data=1 picks b high", 10'h3FF);
      si = 0; idle(4);
      chk("R2 data=0 picks a", 10'h000);

      en = 1; idle(4);
      chk("R6 enable rise clears", 10'h000);
      ra = 1; rb = 1; idle(1);
      chk("R5 before commit all low", 10'h000);

      // word: select b, enable outputs 0, 2, 9
      send_bits(11'h681, 11);
      chk("R5 eleven pulses no commit", 10'h000);
      pulse(1'b0);
      chk("R3 committed pattern", 10'h205);
      ra = 1; rb = 0; idle(1);
      chk("R4 select b, a high", 10'h000);
      ra = 0; rb = 1; idle(1);
      chk("R4 select b, b high", 10'h205);

      pulse(1'b1); pulse(1'b0); pulse(1'b1);
      chk("R7 extra pulses ignored", 10'h205);

      en = 0; si = 0; ra = 1; rb = 0; idle(4);
      chk("R2 back to fallback", 10'h3FF);

      // aborted load
      rb = 1; en = 1; idle(4);
      chk("R6 second rise clears", 10'h000);
      send_bits(11'h7FF, 5);
      chk("R9 partial load no output", 10'h000);
      en = 0; si = 0; rb = 0; idle(4);
      chk("R9 abort falls back", 10'h3FF);
      rb = 1; en = 1; idle(4);
      chk("R6 rise after abort", 10'h000);
      send_bits(11'h01E, 11);
      chk("R9 count restarted", 10'h000);
      pulse(1'b1);
      ra = 1; rb = 0; idle(1);
      chk("R5 second commit select a", 10'h1E0);
      ra = 0; rb = 1; idle(1);
      chk("R4 select a, b high", 10'h000);
      ra = 1; idle(1);
      chk("R8 disabled outputs low", 10'h1E0);

      // repeated load-enable rise
      en = 0; idle(4); en = 1; idle(4);
      chk("R6 repeated rise clears", 10'h000);

      done = 1;
      idle(2);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog: out=%h expected=completion", out);
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

endmodule